// File: doc/BRIEF.md
# I/O Flow Reservation Controller

This block decides, cycle by cycle, which of several DMA bridges may move data over a shared memory path. Each bridge raises a data-ready line when it holds buffered traffic. It receives a block line back, and the bridge transfers only while that line is low. At most one bridge is unblocked at any time, so bus access is scheduled like tasks on a single processor and is not left to a round-robin bus arbiter.

Each flow has its own budget server. The server counts the cycles the flow actually transfers and takes its eligibility away once the budget is spent. It returns every consumed slice one period after that slice began, which is sporadic-server replenishment. A strict priority selector grants the lowest-indexed eligible flow. Flows are wired in rate-monotonic order, so a shorter period goes to a lower index. Budget and period per flow are static configuration inputs. The budget is loaded into the server at reset. A global enable input switches to an uncontrolled mode in which every block line is low.

Each server is a small state machine with three states:
- `SRV_IDLE`: no transfer slice is open and capacity remains.
- `SRV_RUN`: a slice is open and the flow transferred in this cycle.
- `SRV_DEPLETED`: the capacity is zero.

The server moves between these states as follows:
- `SRV_IDLE` → `SRV_RUN` on the first transfer cycle.
- `SRV_RUN` → `SRV_IDLE` when the transfer stops and capacity is left.
- `SRV_RUN` → `SRV_DEPLETED` when the transfer stops and no capacity is left.
- `SRV_DEPLETED` → `SRV_IDLE` when a replenishment arrives.

Top module: `rc_io_reservation_ctrl`

## Requirements
- R1: After reset, with enable high and no data-ready, every block output is 1 and every server holds its full configured budget.
- R2: While enable is high, at most one block output is 0 in any cycle.
- R3: Grants are strict fixed priority: in the cycle after flow k is eligible, no flow with an index above k is unblocked.
- R4: A block output goes to 0 in a cycle only if that flow's data-ready was high in the previous cycle.
- R5: A flow transfers (unblocked with data-ready high) for at most its budget cycles before a replenishment. With continuous data-ready and no competition, it is unblocked for exactly its budget in the first ten cycles when budget=3 and period=10.
- R6: The cycles consumed in a slice that starts at cycle t0 are returned in cycle t0+period, and the flow can be unblocked again at t0+period+1. Capacity never exceeds the budget.
- R7: A server with REPL_DEPTH replenishments pending does not start a new slice until one of them has been returned.
- R8: While enable is low, every block output is 0 and no budget is consumed.
- R9: When a higher-priority flow exhausts its budget, the next eligible flow is unblocked in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sched_en_i | input | 1 | 1 = reservation scheduling, 0 = all block outputs low |
| cfg_budget_i | input | N_FLOWS*BUD_W | Budget per flow in cycles; flow i at bits [i*BUD_W +: BUD_W] |
| cfg_period_i | input | N_FLOWS*TIME_W | Replenishment period per flow, larger than its budget; flow i at [i*TIME_W +: TIME_W] |
| data_rdy_i | input | N_FLOWS | Bridge i has buffered data |
| block_o | output | N_FLOWS | 1 = bridge i must hold its transfers |

## Verification
The bench builds the block with three flows, 4-bit budgets, a 12-bit timer and a replenishment queue only two entries deep. The budgets and periods are 3/10, 4/16 and 6/40, so exhaustion, replenishment and a full queue all occur within a few dozen cycles. Short one-cycle bursts fill the two-entry queue quickly, so the rule that a new slice waits for a returned replenishment is reached. A behavioural reference model with dynamic queues is compared against every block output on every cycle. This covers directed contention, toggled bursts and a long pseudo-random phase with enable switching.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        SRV_IDLE     = 2'd0,
        SRV_RUN      = 2'd1,
        SRV_DEPLETED = 2'd2
    } srv_state_e;

endpackage

// File: rtl/rc_repl_queue.sv
module rc_repl_queue #(
    parameter int BUD_W  = 8,
    parameter int TIME_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [TIME_W-1:0] push_time_i,
    input  logic [BUD_W-1:0]  push_amt_i,
    input  logic              pop_i,
    output logic [TIME_W-1:0] head_time_o,
    output logic [BUD_W-1:0]  head_amt_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [TIME_W-1:0] time_mem [DEPTH];
    logic [BUD_W-1:0]  amt_mem  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (push_i) begin
            time_mem[wr_ptr] <= push_time_i;
            amt_mem[wr_ptr]  <= push_amt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
            count_o <= count_o + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assign head_time_o = time_mem[rd_ptr];
    assign head_amt_o  = amt_mem[rd_ptr];

    AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i) |-> (count_o < CNT_W'(DEPTH)));  // R7
    AST_QUEUE_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (count_o != '0));  // R6

endmodule

// File: rtl/rc_flow_server.sv
module rc_flow_server
    import rc_pkg::*;
#(
    parameter int BUD_W      = 8,
    parameter int TIME_W     = 16,
    parameter int REPL_DEPTH = 4,
    localparam int CNT_W     = $clog2(REPL_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sched_en_i,
    input  logic              data_rdy_i,
    input  logic              exec_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [BUD_W-1:0]  cfg_budget_i,
    input  logic [TIME_W-1:0] cfg_period_i,
    output logic              ready_o
);

    srv_state_e        state_q, state_d;
    logic [BUD_W-1:0]  cap_q, cap_d;
    logic [BUD_W-1:0]  slice_amt_q;
    logic [TIME_W-1:0] slice_t0_q;
    logic              use_c, push_c, pop_c;
    logic [TIME_W-1:0] head_time;
    logic [BUD_W-1:0]  head_amt;
    logic [CNT_W-1:0]  q_count;
    logic [CNT_W:0]    q_count_d;

    assign use_c  = sched_en_i && exec_i && data_rdy_i;
    assign push_c = (state_q == SRV_RUN) && !use_c;
    assign pop_c  = (q_count != '0) && (head_time == now_i);

    rc_repl_queue #(
        .BUD_W (BUD_W),
        .TIME_W(TIME_W),
        .DEPTH (REPL_DEPTH)
    ) repl_q_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push_c),
        .push_time_i(slice_t0_q + cfg_period_i),
        .push_amt_i (slice_amt_q),
        .pop_i      (pop_c),
        .head_time_o(head_time),
        .head_amt_o (head_amt),
        .count_o    (q_count)
    );

    always_comb begin
        cap_d     = cap_q - BUD_W'(use_c) + (pop_c ? head_amt : '0);
        q_count_d = (CNT_W+1)'(q_count) + (CNT_W+1)'(push_c) - (CNT_W+1)'(pop_c);
        state_d   = state_q;
        unique case (state_q)
            SRV_IDLE:     if (use_c) state_d = SRV_RUN;
            SRV_RUN:      if (!use_c) state_d = (cap_d == '0) ? SRV_DEPLETED : SRV_IDLE;
            SRV_DEPLETED: if (cap_d != '0) state_d = SRV_IDLE;
            default:      state_d = SRV_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= SRV_IDLE;
            cap_q       <= cfg_budget_i;
            slice_amt_q <= '0;
            slice_t0_q  <= '0;
        end else begin
            state_q <= state_d;
            cap_q   <= cap_d;
            if (use_c && state_q != SRV_RUN) begin
                slice_t0_q  <= now_i;
                slice_amt_q <= BUD_W'(1);
            end else if (use_c) begin
                slice_amt_q <= slice_amt_q + 1'b1;
            end
        end
    end

    always_comb begin
        ready_o = sched_en_i && data_rdy_i && (cap_d != '0)
                  && (use_c || (q_count_d < (CNT_W+1)'(REPL_DEPTH)));
    end

    AST_NO_BUDGET_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        use_c |-> (cap_q != '0));  // R5
    AST_CAP_WITHIN_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q <= cfg_budget_i);  // R6
    AST_READY_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> data_rdy_i);  // R4
    AST_DISABLED_NO_SPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sched_en_i |=> (cap_q >= $past(cap_q)));  // R8

endmodule

// File: rtl/rc_prio_sel.sv
module rc_prio_sel #(
    parameter int N_FLOWS = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_FLOWS-1:0] ready_i,
    output logic [N_FLOWS-1:0] exec_o
);

    logic [N_FLOWS-1:0] exec_d;

    always_comb begin
        exec_d = '0;
        for (int k = N_FLOWS - 1; k >= 0; k--) begin
            if (ready_i[k]) exec_d = N_FLOWS'(1) << k;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) exec_o <= '0;
        else         exec_o <= exec_d;
    end

    for (genvar g = 1; g < N_FLOWS; g++) begin : g_prio_chk
        AST_HIGHER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ready_i[g-1] |=> !exec_o[g]);  // R3
    end

endmodule

// File: rtl/rc_io_reservation_ctrl.sv
module rc_io_reservation_ctrl #(
    parameter int N_FLOWS    = 4,
    parameter int BUD_W      = 8,
    parameter int TIME_W     = 16,
    parameter int REPL_DEPTH = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      sched_en_i,
    input  logic [N_FLOWS*BUD_W-1:0]  cfg_budget_i,
    input  logic [N_FLOWS*TIME_W-1:0] cfg_period_i,
    input  logic [N_FLOWS-1:0]        data_rdy_i,
    output logic [N_FLOWS-1:0]        block_o
);

    logic [TIME_W-1:0]  now_q;
    logic [N_FLOWS-1:0] ready;
    logic [N_FLOWS-1:0] exec;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) now_q <= '0;
        else         now_q <= now_q + 1'b1;
    end

    for (genvar i = 0; i < N_FLOWS; i++) begin : g_server
        rc_flow_server #(
            .BUD_W     (BUD_W),
            .TIME_W    (TIME_W),
            .REPL_DEPTH(REPL_DEPTH)
        ) server_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .sched_en_i  (sched_en_i),
            .data_rdy_i  (data_rdy_i[i]),
            .exec_i      (exec[i]),
            .now_i       (now_q),
            .cfg_budget_i(cfg_budget_i[i*BUD_W +: BUD_W]),
            .cfg_period_i(cfg_period_i[i*TIME_W +: TIME_W]),
            .ready_o     (ready[i])
        );
    end

    rc_prio_sel #(.N_FLOWS(N_FLOWS)) sel_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ready_i(ready),
        .exec_o (exec)
    );

    assign block_o = sched_en_i ? ~exec : '0;

    AST_SINGLE_UNBLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sched_en_i |-> ($countones(~block_o) <= 1));  // R2
    AST_UNBLOCK_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sched_en_i && $past(sched_en_i) && $past(rst_ni)) |->
            ((~block_o & ~$past(data_rdy_i)) == '0));  // R4

endmodule

// File: tb/rc_io_reservation_ctrl_tb.sv
module rc_io_reservation_ctrl_tb_top;

    localparam int N  = 3;
    localparam int BW = 4;
    localparam int TW = 12;
    localparam int QD = 2;

    localparam int BUD [N] = '{3, 4, 6};
    localparam int PER [N] = '{10, 16, 40};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [N-1:0]  rdy = '0;
    logic [N-1:0]  block;
    logic [N*BW-1:0] cfg_b;
    logic [N*TW-1:0] cfg_p;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_cfg
        assign cfg_b[i*BW +: BW] = BW'(BUD[i]);
        assign cfg_p[i*TW +: TW] = TW'(PER[i]);
    end

    rc_io_reservation_ctrl #(
        .N_FLOWS(N), .BUD_W(BW), .TIME_W(TW), .REPL_DEPTH(QD)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sched_en_i(en),
        .cfg_budget_i(cfg_b), .cfg_period_i(cfg_p),
        .data_rdy_i(rdy), .block_o(block)
    );

    // behavioural reference model
    int m_cap [N];
    bit m_exec [N];
    bit m_open [N];
    int m_t0 [N];
    int m_acc [N];
    int q_t [N][$];
    int q_a [N][$];
    int m_now;
    logic [N-1:0] prev_rdy;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cap[i] = BUD[i]; m_exec[i] = 0; m_open[i] = 0;
                m_t0[i] = 0; m_acc[i] = 0;
                q_t[i].delete(); q_a[i].delete();
            end
            m_now = 0;
            prev_rdy <= '0;
        end else begin
            bit rd [N];
            bit taken;
            for (int i = 0; i < N; i++) begin
                bit u, pu, po;
                int cnt;
                u  = en && m_exec[i] && rdy[i];
                pu = m_open[i] && !u;
                po = (q_t[i].size() > 0) && (q_t[i][0] == m_now);
                if (pu) begin
                    q_t[i].push_back(m_t0[i] + PER[i]);
                    q_a[i].push_back(m_acc[i]);
                end
                if (po) begin
                    m_cap[i] += q_a[i][0];
                    void'(q_t[i].pop_front());
                    void'(q_a[i].pop_front());
                end
                if (u) begin
                    m_cap[i]--;
                    if (!m_open[i]) begin m_t0[i] = m_now; m_acc[i] = 1; end
                    else m_acc[i]++;
                end
                m_open[i] = u;
                cnt = q_t[i].size();
                rd[i] = en && rdy[i] && (m_cap[i] > 0) && (u || cnt < QD);
            end
            taken = 0;
            for (int i = 0; i < N; i++) begin
                m_exec[i] = rd[i] && !taken;
                if (rd[i]) taken = 1;
            end
            m_now++;
            prev_rdy <= rdy;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] exp_b;
            for (int i = 0; i < N; i++) exp_b[i] = en ? !m_exec[i] : 1'b0;
            checks++;
            if (block !== exp_b) begin
                fails++;
                $display("FAIL %s cycle=%0d block_o actual=%b expected=%b", cur_req, cycles, block, exp_b);
            end
            if (en) begin
                checks++;
                if ($countones(~block) > 1) begin
                    fails++;
                    $display("FAIL R2 unblocked actual=%b expected=at most one zero", block);
                end
                checks++;
                if ((~block & ~prev_rdy) != '0) begin
                    fails++;
                    $display("FAIL R4 unblocked actual=%b prev data_rdy=%b expected=subset", ~block, prev_rdy);
                end
            end
        end
    end

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit en_after);
        rdy = '0;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        en = en_after;
    endtask

    initial begin
        int cnt;
        logic [15:0] lfsr;
        step(1);
        // R1: reset state
        cur_req = "R1";
        do_reset(1'b1);
        step(2);
        check("R1", 32'(block), 32'(3'b111));

        // R5 / R6: flow 0 alone
        cur_req = "R5";
        rdy = 3'b001;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (!block[0]) cnt++;
        end
        check("R5", 32'(cnt), 32'd3);
        cur_req = "R6";
        step(1);
        check("R6", 32'(block[0]), 32'd1);
        step(1);
        check("R6", 32'(block[0]), 32'd0);
        step(20);

        // R9: exhaustion hands over to the next flow
        cur_req = "R9";
        do_reset(1'b1);
        rdy = 3'b111;
        step(4);
        check("R9", 32'(block), 32'(3'b101));
        cur_req = "R3";
        step(200);

        // R8: uncontrolled mode spends nothing
        cur_req = "R8";
        do_reset(1'b0);
        rdy = 3'b111;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (block != '0) cnt++;
        end
        check("R8", 32'(cnt), 32'd0);
        en = 1'b1;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (!block[0]) cnt++;
        end
        check("R8", 32'(cnt), 32'd3);

        // R7: one-cycle bursts fill the replenishment queue
        cur_req = "R7";
        do_reset(1'b1);
        for (int k = 0; k < 60; k++) begin
            rdy = {2'b00, ~rdy[0]};
            step(1);
        end
        rdy = '0;
        step(30);

        // pseudo-random traffic with enable switching
        cur_req = "R5";
        do_reset(1'b1);
        lfsr = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = lfsr[2:0] | {lfsr[7], 2'b00};
            if (lfsr[15:11] == 5'd0) en = ~en;
            step(1);
        end
        en = 1'b1;
        step(5);
        print_summary();
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        print_summary();
    end

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

endmodule